// File: doc/BRIEF.md
# Processor Interrupt Level Priority Resolver

This block decides which maskable interrupt level a processor core should take next. It merges the external level lines with the software-interrupt register. Two timer-match flags in that register do not act as levels of their own. Instead they make level 14 pending. The block then compares the merged vector against the core's current priority level and keeps a registered trap index plus a hard request line for the core.

Several conditions hold back or withdraw the request. While a vectored interrupt is being delivered, the resolver freezes its outputs. When nothing above the current level is pending, or when interrupts are globally disabled, an active request is dropped and the index returns to zero. When the core is already inside a trap for a higher external level, the resolver does not raise a lower external level over it. A new request is loaded only when the chosen index differs from the index already held. The block is recomputed every clock cycle, and results appear one cycle after the inputs.

Top module: `irq_lvl_resolver`

## Requirements
- R1: After reset, `irqIdx` is 0 and `irqReq` is 0. From then on, `irqIdx` is nonzero exactly while `irqReq` is high.
- R2: The pending vector is `extLvl` ORed with `softInt[15:1]` on levels 15..1. `softInt[0]` and `softInt[16]` are timer-match flags, and they never pend level 0 or a level 16. If either flag is set, level 14 is pending.
- R3: While `vecBusy` is 1, `irqIdx` and `irqReq` keep their values at the next clock edge, whatever the other inputs are.
- R4: Suppose `vecBusy` is 0 and no pending bit lies above `curLvl`, i.e. pending < (2 << curLvl). If a request is active, it is withdrawn and the index is cleared one cycle later. If no request is active, both outputs stay unchanged.
- R5: Suppose `vecBusy` is 0, `intEn` is 1, something above `curLvl` is pending and no suppression applies. Then the highest pending level k wins, and one cycle later `irqIdx` = 0x40 | k and `irqReq` = 1.
- R6: A new index n is not loaded when all of the following hold: `trapLvl` > 0, `curTT` > n, and `curTT[8:4]` equals 0x40 >> 4. In that case both outputs stay unchanged.
- R7: When the winning index equals the index already held, the outputs stay unchanged.
- R8: Suppose `vecBusy` is 0, `intEn` is 0 and something above `curLvl` is pending. An active request is then withdrawn and the index is cleared. With no active request, nothing changes.

Together, `curLvl` = 15 means that no level can ever be above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extLvl | input | 16 | External interrupt level lines, bit n = level n |
| softInt | input | 17 | Software-interrupt register; bit 0 and bit 16 are timer-match flags |
| curLvl | input | 4 | Current processor interrupt level |
| intEn | input | 1 | Global interrupt enable |
| vecBusy | input | 1 | A vectored interrupt is being delivered |
| trapLvl | input | 3 | Current trap nesting level |
| curTT | input | 9 | Trap type currently being serviced |
| irqIdx | output | 9 | Registered interrupt trap index |
| irqReq | output | 1 | Hard interrupt request to the core |

## Verification
The hardest case to reach is the suppression rule. It needs a raised trap level, an external-type trap type above the candidate index, and no request already holding that index, all in the same cycle. The bench builds this case by hand with trap types just above, equal to and below the candidate. It also uses non-external trap types and a zero trap level. A sparse pseudo-random run then mixes these conditions with busy and enable changes. The same run pins the timer-match folding by placing each software bit alone.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  typedef struct packed {
    logic load;   // take the new winning index and raise the request
    logic clear;  // drop the request and zero the index
  } irqStrobe_t;
endpackage

// File: rtl/irq_lvl_dp.sv
module irq_lvl_dp
  import irq_lvl_pkg::*;
#(
  parameter int LVL_N    = 16,
  parameter int TT_W     = 9,
  parameter int TL_W     = 3,
  parameter int FOLD_LVL = 14,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_N-1:0]         extLvl,
  input  logic [LVL_N:0]           softInt,
  input  logic [$clog2(LVL_N)-1:0] curLvl,
  input  logic [TL_W-1:0]          trapLvl,
  input  logic [TT_W-1:0]          curTT,
  input  irqStrobe_t               strb,
  output logic                     anyAbove,
  output logic                     suppress,
  output logic                     differs,
  output logic [TT_W-1:0]          idxQ
);
  localparam int LW = $clog2(LVL_N);
  localparam logic [TT_W-1:0] BASE_HI = EXT_BASE >> LW;

  logic [LVL_N-1:0] pend;
  logic [LVL_N:0]   thresh;
  logic [LW-1:0]    winLvl;
  logic [TT_W-1:0]  newIdx;

  // merge sources; timer-match flags fold onto one level
  always_comb begin
    pend = extLvl | {softInt[LVL_N-1:1], 1'b0};
    if (softInt[0] | softInt[LVL_N]) pend[FOLD_LVL] = 1'b1;
  end

  assign thresh   = (LVL_N+1)'(2) << curLvl;
  assign anyAbove = {1'b0, pend} >= thresh;

  // highest set bit; only meaningful when anyAbove
  always_comb begin
    winLvl = '0;
    for (int i = 0; i < LVL_N; i++)
      if (pend[i]) winLvl = LW'(i);
  end

  assign newIdx   = EXT_BASE | TT_W'(winLvl);
  assign suppress = (trapLvl != '0) && (curTT > newIdx) && ((curTT >> LW) == BASE_HI);
  assign differs  = newIdx != idxQ;

  always_ff @(posedge clk) begin
    if (!rstN)          idxQ <= '0;
    else if (strb.clear) idxQ <= '0;
    else if (strb.load)  idxQ <= newIdx;
  end
endmodule

// File: rtl/irq_lvl_ctl.sv
module irq_lvl_ctl
  import irq_lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vecBusy,
  input  logic       intEn,
  input  logic       anyAbove,
  input  logic       suppress,
  input  logic       differs,
  output irqStrobe_t strb,
  output logic       reqQ
);
  always_comb begin
    strb = '0;
    if (!vecBusy) begin
      if (!anyAbove)                 strb.clear = reqQ;
      else if (intEn)                strb.load  = !suppress && differs;
      else                           strb.clear = reqQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          reqQ <= 1'b0;
    else if (strb.clear) reqQ <= 1'b0;
    else if (strb.load)  reqQ <= 1'b1;
  end
endmodule

// File: rtl/irq_lvl_resolver.sv
module irq_lvl_resolver
  import irq_lvl_pkg::*;
#(
  parameter int LVL_N    = 16,
  parameter int TT_W     = 9,
  parameter int TL_W     = 3,
  parameter int FOLD_LVL = 14,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LVL_N-1:0]         extLvl,
  input  logic [LVL_N:0]           softInt,
  input  logic [$clog2(LVL_N)-1:0] curLvl,
  input  logic                     intEn,
  input  logic                     vecBusy,
  input  logic [TL_W-1:0]          trapLvl,
  input  logic [TT_W-1:0]          curTT,
  output logic [TT_W-1:0]          irqIdx,
  output logic                     irqReq
);
  irqStrobe_t strb;
  logic anyAbove, suppress, differs;

  irq_lvl_dp #(.LVL_N(LVL_N), .TT_W(TT_W), .TL_W(TL_W),
               .FOLD_LVL(FOLD_LVL), .EXT_BASE(EXT_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .extLvl(extLvl), .softInt(softInt),
    .curLvl(curLvl), .trapLvl(trapLvl), .curTT(curTT), .strb(strb),
    .anyAbove(anyAbove), .suppress(suppress), .differs(differs), .idxQ(irqIdx)
  );

  irq_lvl_ctl ctl_i (
    .clk(clk), .rstN(rstN), .vecBusy(vecBusy), .intEn(intEn),
    .anyAbove(anyAbove), .suppress(suppress), .differs(differs),
    .strb(strb), .reqQ(irqReq)
  );
endmodule

// File: rtl/irq_lvl_chk.sv
module irq_lvl_chk #(
  parameter int LVL_N = 16,
  parameter int TT_W  = 9,
  parameter int TL_W  = 3,
  parameter logic [TT_W-1:0] EXT_BASE = 9'h040
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [LVL_N-1:0]         extLvl,
  input logic [LVL_N:0]           softInt,
  input logic [$clog2(LVL_N)-1:0] curLvl,
  input logic                     intEn,
  input logic                     vecBusy,
  input logic [TT_W-1:0]          irqIdx,
  input logic                     irqReq
);
  localparam int LW = $clog2(LVL_N);

  p_idx_req_pair_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (irqIdx != '0));

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    vecBusy |=> $stable(irqIdx) && $stable(irqReq));

  p_quiet_withdraw_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && extLvl == '0 && softInt == '0 && irqReq) |=> (!irqReq && irqIdx == '0));

  p_raise_above_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> (irqIdx[LW-1:0] > $past(curLvl)) && ((irqIdx >> LW) == (EXT_BASE >> LW)));

  p_disabled_withdraw_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && !intEn && irqReq) |=> (!irqReq && irqIdx == '0));
endmodule

bind irq_lvl_resolver irq_lvl_chk #(.LVL_N(LVL_N), .TT_W(TT_W), .TL_W(TL_W),
                                    .EXT_BASE(EXT_BASE)) chk_i (
  .clk(clk), .rstN(rstN), .extLvl(extLvl), .softInt(softInt), .curLvl(curLvl),
  .intEn(intEn), .vecBusy(vecBusy), .irqIdx(irqIdx), .irqReq(irqReq)
);

// File: tb/irq_lvl_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_lvl_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] extLvl = '0;
  logic [16:0] softInt = '0;
  logic [3:0]  curLvl = '0;
  logic        intEn = 1'b0;
  logic        vecBusy = 1'b0;
  logic [2:0]  trapLvl = '0;
  logic [8:0]  curTT = '0;
  logic [8:0]  irqIdx;
  logic        irqReq;

  int total = 0;
  int bad = 0;
  int mIdx = 0;
  bit mReq = 0;
  string mTag;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  irq_lvl_resolver dut_i (
    .clk(clk), .rstN(rstN), .extLvl(extLvl), .softInt(softInt), .curLvl(curLvl),
    .intEn(intEn), .vecBusy(vecBusy), .trapLvl(trapLvl), .curTT(curTT),
    .irqIdx(irqIdx), .irqReq(irqReq)
  );

  // reference: advance expected state for the inputs present at this edge
  task automatic modelEdge();
    int pend, thr, win, n;
    pend = int'(extLvl) | (int'(softInt) & 32'hFFFE);
    if (softInt[0] || softInt[16]) pend = pend | (1 << 14);
    thr = 2 << curLvl;
    if (vecBusy) mTag = "R3";
    else if (pend < thr) begin
      mTag = "R4";
      if (mReq) begin mReq = 0; mIdx = 0; end
    end else if (intEn) begin
      win = -1;
      for (int k = 15; k > int'(curLvl); k--)
        if (win < 0 && pend[k]) win = k;
      n = 64 + win;
      if (trapLvl > 0 && int'(curTT) > n && (int'(curTT) >> 4) == 4) mTag = "R6";
      else if (n != mIdx) begin mTag = "R5"; mIdx = n; mReq = 1; end
      else mTag = "R7";
    end else begin
      mTag = "R8";
      if (mReq) begin mReq = 0; mIdx = 0; end
    end
  endtask

  task automatic check(string tag);
    total++;
    if (int'(irqIdx) != mIdx || irqReq != mReq) begin
      bad++;
      $display("FAIL %s: idx=%h req=%0d expected idx=%h req=%0d", tag, irqIdx, irqReq, mIdx[8:0], mReq);
    end
  endtask

  // inputs already set at a negedge; clock once and compare
  task automatic step(string tagOverride = "");
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tagOverride == "" ? mTag : tagOverride);
  endtask

  task automatic setIn(logic [15:0] e, logic [16:0] s, logic [3:0] l, logic en,
                       logic bz, logic [2:0] tl, logic [8:0] tt);
    extLvl = e; softInt = s; curLvl = l; intEn = en; vecBusy = bz; trapLvl = tl; curTT = tt;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: idx=%h req=%0d expected completion", irqIdx, irqReq);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");                      // reset state
    rstN = 1'b1;

    // R5/R4: every level against every current level
    for (int l = 0; l < 16; l++)
      for (int b = 0; b < 16; b++) begin
        setIn(16'(1 << b), '0, 4'(l), 1'b1, 1'b0, '0, '0); step();
        setIn('0, '0, 4'(l), 1'b1, 1'b0, '0, '0); step();
      end

    // R5: highest of several wins
    setIn(16'h0A50, '0, 4'd2, 1'b1, 1'b0, '0, '0); step("R5");
    setIn(16'h0A58, '0, 4'd2, 1'b1, 1'b0, '0, '0); step("R7");
    setIn(16'h8001, '0, 4'd14, 1'b1, 1'b0, '0, '0); step("R5");
    setIn('0, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R4");

    // R2: each software bit alone
    for (int b = 0; b < 17; b++) begin
      setIn('0, 17'(1 << b), 4'd0, 1'b1, 1'b0, '0, '0); step("R2");
      setIn('0, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R2");
    end
    setIn('0, 17'h10001, 4'd13, 1'b1, 1'b0, '0, '0); step("R2");
    setIn('0, 17'h10001, 4'd14, 1'b1, 1'b0, '0, '0); step("R2");

    // R8: disable while active, and disable with nothing active
    setIn(16'h0200, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R5");
    setIn(16'h0200, '0, 4'd0, 1'b0, 1'b0, '0, '0); step("R8");
    setIn(16'h0200, '0, 4'd0, 1'b0, 1'b0, '0, '0); step("R8");

    // R3: busy freezes both directions
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R5");
    setIn(16'h0200, '0, 4'd0, 1'b1, 1'b1, '0, '0); step("R3");
    setIn('0, '0, 4'd0, 1'b0, 1'b1, '0, '0); step("R3");
    setIn(16'h0200, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R5");
    setIn('0, '0, 4'd0, 1'b1, 1'b0, '0, '0); step("R4");
    setIn(16'h4000, '0, 4'd0, 1'b1, 1'b1, '0, '0); step("R3");

    // R6: suppression by a higher external trap in progress
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A); step("R6");
    setIn(16'h0400, '0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A); step("R6");
    setIn(16'h0800, '0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A); step("R6");
    setIn('0, '0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A); step("R4");
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h04A); step("R6");
    setIn('0, '0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h04A); step("R4");
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, 3'd2, 9'h05F); step("R6");
    setIn('0, '0, 4'd0, 1'b1, 1'b0, 3'd0, 9'h04A); step("R4");
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, 3'd2, 9'h04F); step("R6");
    setIn(16'h0020, '0, 4'd0, 1'b1, 1'b0, 3'd1, 9'h04A); step("R7");

    // mixed sparse pseudo-random run
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr * 32'h9E37_79B9;
      b = (lfsr ^ 32'h5A5A_1234) * 32'h85EB_CA6B;
      setIn(a[15:0] & b[15:0] & a[31:16], {b[4], 16'h0, b[5]} | (17'(a[27:24]) << 3 & 17'(b[29:26]) << 3),
            a[19:16] & b[3:0], |b[9:7], b[12] & b[13], {1'b0, b[15:14]},
            b[16] ? {5'h04, a[23:20]} : {a[24:20], b[20:17]});
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule